// File: doc/BRIEF.md
# Instrument Status and Service-Request Unit

This block holds the status reporting state of an instrument controller. One-cycle event pulses (operation complete, query error, device error, execution error, command error) are caught in a sticky event register. A power-on flag is set in that register by reset. Test-status pulses (all pass, fail, abort, test in process) are caught in sticky condition bits of a status byte. Each register has an enable mask. The enabled event bits are ORed into an event summary output. The enabled condition bits drive a service-request line, which is also mirrored in bit 6 of the status byte.

A host reaches the registers through a single-cycle request port. That port is always ready and accepts one access per cycle, with no back-pressure. A read answers on the response pins exactly one cycle later. A separate serial-poll strobe returns the status byte one cycle later and withdraws the pending request. Non-volatile storage of the power-on-clear choice sits outside the block. Its value is exported on `pon_flag_o` and fed back at reset on `pon_flag_ret_i`.

Top module: `instr_status_unit`

## Requirements
- R1: The event register uses bit 0 operation complete, bit 2 query error, bit 3 device error, bit 4 execution error, bit 5 command error and bit 7 power on. A pulse on `evt_pulse_i[k]` sets bit k for those bits only. Bits 1 and 6 always read 0.
- R2: A read of address 0 returns the event register and clears it in the same access. A pulse arriving in that cycle is kept and is visible at the next read.
- R3: The status byte holds all pass in bit 0, fail in bit 1, abort in bit 2 and test in process in bit 3, with the request bit in bit 6. Bits 4, 5 and 7 read 0. A read of address 2 returns the byte and clears bits 0 to 3, keeping a same-cycle test pulse. Bits 0 to 3 are unchanged by a serial poll.
- R4: Address 1 (event enable) and address 3 (service enable) are read/write. Writes are masked to the defined bits, 0xBD and 0x0F respectively. A write to address 4 (clear status) clears the event register and leaves both enable registers unchanged. Writes to addresses 0 and 2 are ignored.
- R5: `evt_summary_o` is 1 exactly when some event bit and its enable bit are both 1.
- R6: `srq_o` and status bit 6 are 1 only while some condition bit and its service-enable bit are both 1.
- R7: A serial poll returns the status byte from the strobe cycle and then clears the request bit. With all-pass enabled and a pass latched, the poll returns 0x41 and `srq_o` falls in the next cycle.
- R8: After a poll, the request re-asserts only after the enabled summary has gone to 0 and risen again. The rise shows on `srq_o` two cycles after the setting pulse.
- R9: Reset sets the event register to 0x80 and clears the condition bits. Reset clears both enable registers when `pon_flag_ret_i` is 1 and keeps them when it is 0. `pon_flag_o` loads `pon_flag_ret_i` at reset and is written by bit 0 of a write to address 5, which also reads back there.
- R10: `rsp_valid_o` is 1 exactly one cycle after each read request. `poll_valid_o` is 1 exactly one cycle after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pon_flag_ret_i | input | 1 | Retained power-on-clear flag presented during reset |
| pon_flag_o | output | 1 | Current power-on-clear flag for external retention |
| evt_pulse_i | input | 8 | Event pulses, one bit per event |
| test_pulse_i | input | 4 | Test-status pulses |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Register address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 8 | Read data |
| poll_i | input | 1 | Serial-poll strobe |
| poll_valid_o | output | 1 | Poll result valid |
| poll_data_o | output | 8 | Polled status byte |
| srq_o | output | 1 | Service request |
| evt_summary_o | output | 1 | Enabled event summary |

## Verification
The hardest state to reach is a second service request raised by the same condition source after a poll. The bench must poll, show that the request stays low while the condition persists, and then clear the condition through a status read. A fresh pulse must then come while the enable is still set. Directed sequences build that chain, along with same-cycle pulse-and-clear collisions and a reset with the retained flag at 0. Long random phases with sparse resets and polls then compare every output to a bench model on every cycle.

// File: rtl/instr_status_pkg.sv
package instr_status_pkg;
  localparam int REG_W   = 8;
  localparam int TEST_W  = 4;
  localparam int ADDR_W  = 3;
  localparam int PON_BIT = 7;
  localparam int RQS_BIT = 6;
  localparam logic [REG_W-1:0] EVT_MASK = 8'hBD;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EVT    = 3'd0,
    SEL_EVT_EN = 3'd1,
    SEL_STAT   = 3'd2,
    SEL_SRV_EN = 3'd3,
    SEL_CLS    = 3'd4,
    SEL_PON    = 3'd5
  } sel_e;
endpackage

// File: rtl/sticky_bits.sv
module sticky_bits #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  // clear is applied first, then new pulses, so a colliding pulse survives
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= RST_VAL & MASK;
    else        q_o <= (clr_i ? '0 : q_o) | (set_i & MASK);
  end
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         keep_i,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (!keep_i) q_o <= '0;
    end else if (we_i) begin
      q_o <= d_i & MASK;
    end
  end
endmodule

// File: rtl/srq_gen.sv
module srq_gen #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] en_i,
  input  logic         poll_i,
  output logic         srq_o
);
  logic sum, sum_q, rqs_q, rise;

  assign sum   = |(cond_i & en_i);
  assign rise  = sum & ~sum_q;
  assign srq_o = rqs_q & sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      sum_q <= sum;
      rqs_q <= sum & (rise | (rqs_q & ~poll_i));
    end
  end
endmodule

// File: rtl/instr_status_unit.sv
module instr_status_unit
  import instr_status_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int TW = TEST_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pon_flag_ret_i,
  output logic          pon_flag_o,
  input  logic [RW-1:0] evt_pulse_i,
  input  logic [TW-1:0] test_pulse_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [RW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [RW-1:0] rsp_data_o,
  input  logic          poll_i,
  output logic          poll_valid_o,
  output logic [RW-1:0] poll_data_o,
  output logic          srq_o,
  output logic          evt_summary_o
);
  localparam logic [RW-1:0] EVT_RST = RW'(1) << PON_BIT;
  localparam logic [RW-1:0] SRV_MASK = RW'((1 << TW) - 1);

  sel_e sel;
  logic rd_hit, wr_hit, evt_clr, cond_clr;
  logic [RW-1:0] evt_q, ese_q, sre_q, stat_byte, rd_mux;
  logic [TW-1:0] cond_q;
  logic pon_q;

  assign sel      = sel_e'(req_addr_i);
  assign rd_hit   = req_valid_i & ~req_write_i;
  assign wr_hit   = req_valid_i & req_write_i;
  assign evt_clr  = (rd_hit && sel == SEL_EVT) || (wr_hit && sel == SEL_CLS);
  assign cond_clr = rd_hit && sel == SEL_STAT;

  sticky_bits #(.W(RW), .MASK(EVT_MASK), .RST_VAL(EVT_RST)) u_evt (
    .clk(clk), .rst_n(rst_n), .clr_i(evt_clr), .set_i(evt_pulse_i), .q_o(evt_q));

  sticky_bits #(.W(TW)) u_cond (
    .clk(clk), .rst_n(rst_n), .clr_i(cond_clr), .set_i(test_pulse_i), .q_o(cond_q));

  mask_reg #(.W(RW), .MASK(EVT_MASK)) u_ese (
    .clk(clk), .rst_n(rst_n), .keep_i(~pon_flag_ret_i),
    .we_i(wr_hit && sel == SEL_EVT_EN), .d_i(req_wdata_i), .q_o(ese_q));

  mask_reg #(.W(RW), .MASK(SRV_MASK)) u_sre (
    .clk(clk), .rst_n(rst_n), .keep_i(~pon_flag_ret_i),
    .we_i(wr_hit && sel == SEL_SRV_EN), .d_i(req_wdata_i), .q_o(sre_q));

  srq_gen #(.W(TW)) u_srq (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_q), .en_i(sre_q[TW-1:0]),
    .poll_i(poll_i), .srq_o(srq_o));

  assign evt_summary_o = |(evt_q & ese_q);
  assign pon_flag_o    = pon_q;

  always_comb begin
    stat_byte          = '0;
    stat_byte[TW-1:0]  = cond_q;
    stat_byte[RQS_BIT] = srq_o;
  end

  always_comb begin
    case (sel)
      SEL_EVT:    rd_mux = evt_q;
      SEL_EVT_EN: rd_mux = ese_q;
      SEL_STAT:   rd_mux = stat_byte;
      SEL_SRV_EN: rd_mux = sre_q;
      SEL_PON:    rd_mux = RW'(pon_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pon_q        <= pon_flag_ret_i;
      rsp_valid_o  <= 1'b0;
      rsp_data_o   <= '0;
      poll_valid_o <= 1'b0;
      poll_data_o  <= '0;
    end else begin
      if (wr_hit && sel == SEL_PON) pon_q <= req_wdata_i[0];
      rsp_valid_o  <= rd_hit;
      if (rd_hit) rsp_data_o <= rd_mux;
      poll_valid_o <= poll_i;
      if (poll_i) poll_data_o <= stat_byte;
    end
  end
endmodule

// File: rtl/instr_status_chk.sv
module instr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid_i,
  input logic       req_write_i,
  input logic [2:0] req_addr_i,
  input logic [7:0] evt_pulse_i,
  input logic       rsp_valid_o,
  input logic [7:0] rsp_data_o,
  input logic       poll_i,
  input logic       poll_valid_o,
  input logic [7:0] poll_data_o,
  input logic       srq_o,
  input logic [7:0] evt_q,
  input logic [7:0] ese_q,
  input logic [7:0] sre_q,
  input logic [3:0] cond_q
);
  a_r1_unused_evt_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && $past(req_addr_i) == 3'd0 |-> (rsp_data_o & 8'h42) == 8'h00);

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && !req_write_i && req_addr_i == 3'd0 && evt_pulse_i == 8'h00
    |=> evt_q == 8'h00);

  a_r3_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    poll_valid_o |-> (poll_data_o & 8'hB0) == 8'h00);

  a_r4_cls_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_write_i && req_addr_i == 3'd4
    |=> $stable(ese_q) && $stable(sre_q));

  a_r6_srq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    srq_o |-> (cond_q & sre_q[3:0]) != 4'h0);

  a_r7_poll_bit6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_valid_o |-> poll_data_o[6] == $past(srq_o));

  a_r7_poll_drops: assert property (@(posedge clk) disable iff (!rst_n)
    srq_o && poll_i |=> !srq_o);
endmodule

bind instr_status_unit instr_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .evt_pulse_i(evt_pulse_i), .rsp_valid_o(rsp_valid_o),
  .rsp_data_o(rsp_data_o), .poll_i(poll_i), .poll_valid_o(poll_valid_o),
  .poll_data_o(poll_data_o), .srq_o(srq_o), .evt_q(evt_q), .ese_q(ese_q),
  .sre_q(sre_q), .cond_q(cond_q));

// File: tb/instr_status_unit_tb.sv
module instr_status_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ret = 1'b1;
  logic [7:0] d_ev = '0;
  logic [3:0] d_tp = '0;
  logic d_v = 1'b0, d_w = 1'b0, d_poll = 1'b0;
  logic [2:0] d_a = '0;
  logic [7:0] d_wd = '0;

  logic pon_o, rsp_v, poll_v, srq, esum;
  logic [7:0] rsp_d, poll_d;

  int checks = 0;
  int fails = 0;

  logic [7:0] m_evt, m_ese, m_sre;
  logic [3:0] m_cond;
  logic m_rqs, m_sumq, m_pon;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pon_flag_ret_i(ret), .pon_flag_o(pon_o),
    .evt_pulse_i(d_ev), .test_pulse_i(d_tp), .req_valid_i(d_v), .req_write_i(d_w),
    .req_addr_i(d_a), .req_wdata_i(d_wd), .rsp_valid_o(rsp_v), .rsp_data_o(rsp_d),
    .poll_i(d_poll), .poll_valid_o(poll_v), .poll_data_o(poll_d), .srq_o(srq),
    .evt_summary_o(esum));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic summ(input logic [3:0] c, input logic [7:0] e);
    return |(c & e[3:0]);
  endfunction

  function automatic logic [7:0] stat_of(input logic [3:0] c, input logic r);
    return {1'b0, r, 2'b00, c};
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd2: return "R3";
      3'd5: return "R9";
      default: return "R4";
    endcase
  endfunction

  // one clock: expectations from the model, model update, compare after the edge
  task automatic step();
    logic s, srq_pre, e_rv, e_pv;
    logic [7:0] e_rd, e_pd;
    logic [2:0] a;
    s = summ(m_cond, m_sre);
    srq_pre = m_rqs & s;
    a = d_a;
    e_rv = rst_n && d_v && !d_w;
    e_pv = rst_n && d_poll;
    case (d_a)
      3'd0: e_rd = m_evt;
      3'd1: e_rd = m_ese;
      3'd2: e_rd = stat_of(m_cond, srq_pre);
      3'd3: e_rd = m_sre;
      3'd5: e_rd = {7'b0, m_pon};
      default: e_rd = 8'h00;
    endcase
    e_pd = stat_of(m_cond, srq_pre);
    if (!rst_n) begin
      m_evt = 8'h80; m_cond = '0; m_rqs = 0; m_sumq = 0; m_pon = ret;
      if (ret) begin m_ese = '0; m_sre = '0; end
    end else begin
      m_rqs  = s & ((s & ~m_sumq) | (m_rqs & ~d_poll));
      m_sumq = s;
      m_evt  = (((d_v && !d_w && d_a == 3'd0) || (d_v && d_w && d_a == 3'd4)) ? 8'h00 : m_evt)
               | (d_ev & 8'hBD);
      m_cond = ((d_v && !d_w && d_a == 3'd2) ? 4'h0 : m_cond) | d_tp;
      if (d_v && d_w && d_a == 3'd1) m_ese = d_wd & 8'hBD;
      if (d_v && d_w && d_a == 3'd3) m_sre = d_wd & 8'h0F;
      if (d_v && d_w && d_a == 3'd5) m_pon = d_wd[0];
    end
    @(posedge clk);
    #1;
    chk("R10 rsp_valid", {7'b0, rsp_v}, {7'b0, e_rv});
    if (e_rv) chk(rd_tag(a), rsp_d, e_rd);
    chk("R10 poll_valid", {7'b0, poll_v}, {7'b0, e_pv});
    if (e_pv) chk("R7 poll", poll_d, e_pd);
    chk("R6 srq", {7'b0, srq}, {7'b0, m_rqs & summ(m_cond, m_sre)});
    chk("R5 summary", {7'b0, esum}, {7'b0, |(m_evt & m_ese)});
    chk("R9 pon_flag", {7'b0, pon_o}, {7'b0, m_pon});
  endtask

  task automatic idle();
    d_v = 0; d_w = 0; d_ev = '0; d_tp = '0; d_poll = 0;
  endtask

  task automatic do_rd(input logic [2:0] a);
    idle(); d_v = 1; d_a = a; step(); idle();
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] wd);
    idle(); d_v = 1; d_w = 1; d_a = a; d_wd = wd; step(); idle();
  endtask

  task automatic do_reset(input logic flag);
    idle(); ret = flag; rst_n = 0; step(); step(); rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_evt = '0; m_ese = '0; m_sre = '0; m_cond = '0;
    m_rqs = 0; m_sumq = 0; m_pon = 1;
    do_reset(1'b1);
    chk("R10 reset rsp_valid", {7'b0, rsp_v}, 8'h00);
    chk("R6 reset srq", {7'b0, srq}, 8'h00);
    // R9: power-on bit present after reset; R2: read clears
    do_rd(3'd0); chk("R9 power-on event", rsp_d, 8'h80);
    do_rd(3'd0); chk("R2 cleared", rsp_d, 8'h00);
    // R1: only defined bits latch
    d_ev = 8'hFF; step(); idle();
    do_rd(3'd0); chk("R1 bit map", rsp_d, 8'hBD);
    // R2: collision of read and pulse
    idle(); d_ev = 8'h04; step(); idle();
    d_v = 1; d_a = 3'd0; d_ev = 8'h01; step(); idle();
    chk("R2 old value", rsp_d, 8'h04);
    do_rd(3'd0); chk("R2 pulse kept", rsp_d, 8'h01);
    // R7: all-pass service request
    do_wr(3'd3, 8'hFF);
    do_rd(3'd3); chk("R4 srv enable mask", rsp_d, 8'h0F);
    do_wr(3'd3, 8'h01);
    d_tp = 4'h1; step(); idle();
    step();
    chk("R8 srq after two cycles", {7'b0, srq}, 8'h01);
    d_poll = 1; step(); idle();
    chk("R7 poll value", poll_d, 8'h41);
    chk("R7 srq dropped", {7'b0, srq}, 8'h00);
    d_poll = 1; step(); idle();
    chk("R3 poll keeps cond", poll_d, 8'h01);
    for (int i = 0; i < 5; i++) step();
    chk("R8 no re-assert", {7'b0, srq}, 8'h00);
    do_rd(3'd2); chk("R3 status read", rsp_d, 8'h01);
    step();
    d_tp = 4'h1; step(); idle(); step();
    chk("R8 re-assert on new rise", {7'b0, srq}, 8'h01);
    // R3: write ignored, read clears, test bits map
    d_tp = 4'hE; step(); idle();
    do_wr(3'd2, 8'h00);
    do_rd(3'd2); chk("R3 status byte", rsp_d, 8'h4F);
    do_rd(3'd2); chk("R3 cleared", rsp_d, 8'h00);
    // R4: clear status keeps enables
    do_wr(3'd1, 8'hFF);
    do_rd(3'd1); chk("R4 evt enable mask", rsp_d, 8'hBD);
    d_ev = 8'h20; step(); idle();
    chk("R5 summary set", {7'b0, esum}, 8'h01);
    do_wr(3'd0, 8'h00);
    chk("R4 write to event ignored", {7'b0, esum}, 8'h01);
    do_wr(3'd4, 8'h00);
    chk("R4 cls clears summary", {7'b0, esum}, 8'h00);
    do_rd(3'd1); chk("R4 enable kept", rsp_d, 8'hBD);
    // R9: retained flag controls enable survival
    do_wr(3'd5, 8'h00);
    do_rd(3'd5); chk("R9 flag written", rsp_d, 8'h00);
    do_reset(1'b0);
    do_rd(3'd1); chk("R9 enable kept", rsp_d, 8'hBD);
    do_rd(3'd3); chk("R9 srv enable kept", rsp_d, 8'h01);
    do_reset(1'b1);
    do_rd(3'd1); chk("R9 enable cleared", rsp_d, 8'h00);
    // random phase
    void'($urandom(32'd7321));
    for (int i = 0; i < 6000; i++) begin
      idle();
      d_ev = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      d_tp = (($urandom % 10) == 0) ? 4'($urandom) : 4'h0;
      d_v = (($urandom % 3) == 0);
      d_w = (($urandom % 3) == 0);
      d_a = 3'($urandom % 7);
      d_wd = 8'($urandom);
      d_poll = (($urandom % 6) == 0);
      if (($urandom % 500) == 0) begin
        ret = 1'($urandom);
        rst_n = 0;
      end
      step();
      rst_n = 1;
    end
    idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule